// File: doc/BRIEF.md
# Descending Memory Block Zeroer

This engine clears a run of memory words to zero. A request gives a base address and a word count. The engine writes zero to the highest word of the run first, at base + count - 1, and then works down one word at a time until it reaches the base. Writes go out through a valid/ready write port. A separate one-cycle hint port names addresses that are about to be cleared, so the memory side can fetch them in advance.

The work is split into chunks of `CHUNK` words. The first chunk is the partial one, so every later chunk is full and ends on a chunk-aligned offset. At the start of every chunk the engine looks at the interrupt request. If it is pending, the engine stops and reports how many words are still uncleared. The run goes downward and the base is never changed, so the caller resumes by issuing a new request with the same base and the reported count. No other state has to be saved.

Top module: `blkz_engine`

## Requirements
- R1: For a count c > 0, exactly c writes are issued. Their addresses are base+c-1, base+c-2, down to base, in that order, with no word repeated or skipped.
- R2: A count of 0 produces no write. `done` rises in the second cycle after the cycle in which start was accepted, and `busy` is high for that one cycle in between.
- R3: The first chunk clears ((c-1) mod CHUNK)+1 words. Each later chunk clears exactly CHUNK words.
- R4: `remaining` is loaded with the count when a request is accepted and holds its value while a chunk is being written. At the last write of a chunk it takes the number of words below that chunk, and it is 0 when `done` rises.
- R5: Hint offsets are relative to the base, with L = c-1 the offset of the first word. The cycle after acceptance issues a hint at L-CHUNK, and each chunk start issues one at L-CHUNK*(k+1) for the k-th chunk (k = 1, 2, ...).
- R6: At each chunk start, a pending `irq_pending` stops the engine before any write of that chunk. `suspended` rises and `remaining` equals the number of uncleared words. A new request with the same base and that count clears exactly the rest.
- R7: A hint is issued only when its offset is not negative, that is when the hint address is at or above the base.
- R8: Each write holds `wr_valid` with a stable `wr_addr` until `wr_ready` is high, and `wr_data` is all zeros.
- R9: `busy` is high from acceptance until the engine finishes or suspends. `done` and `suspended` stay set until the next accepted request and are never both set. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted only while idle |
| base_addr | input | ADDR_W | Lowest address of the run |
| count | input | CNT_W | Number of words to clear |
| irq_pending | input | 1 | Interrupt request, sampled at chunk starts |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data, always zero |
| wr_ready | input | 1 | Memory accepts the write this cycle |
| pf_valid | output | 1 | One-cycle prefetch hint |
| pf_addr | output | ADDR_W | Hint address |
| busy | output | 1 | Engine is running |
| done | output | 1 | Last request finished |
| suspended | output | 1 | Last request stopped on interrupt |
| remaining | output | CNT_W | Words still to clear |

## Verification
The bench builds the engine with CHUNK=4, CNT_W=6 and ADDR_W=8. With these values every count from 0 to 63 can be swept in full. That range covers every partial first-chunk length, runs of up to sixteen chunks, and hints that fall below the base. The sweep runs at two bases and under two ready patterns, one always ready and one that stalls every third cycle. Interrupts are raised at the first and at a later chunk boundary, and the bench resumes each stopped run from the reported count, so the full suspend-and-restart path is exercised.

// File: rtl/blkz_pkg.sv
package blkz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_ENTRY  = 2'd2,
    ST_WRITE  = 2'd3
  } blkz_state_e;
endpackage

// File: rtl/blkz_addr_gen.sv
module blkz_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [CNT_W-1:0]  wr_off,
  input  logic [CNT_W-1:0]  pf_off,
  output logic [ADDR_W-1:0] base_hold,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] pf_addr
);
  logic [ADDR_W-1:0] base_q;

  // The base is captured once per request and never stepped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base_in;
  end

  function automatic logic [ADDR_W-1:0] at_offset(input logic [ADDR_W-1:0] b,
                                                  input logic [CNT_W-1:0] off);
    return b + ADDR_W'(off);
  endfunction

  assign base_hold = base_q;
  assign wr_addr   = at_offset(base_q, wr_off);
  assign pf_addr   = at_offset(base_q, pf_off);
endmodule

// File: rtl/blkz_fsm.sv
module blkz_fsm
  import blkz_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CHUNK = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             irq_pending,
  input  logic             wr_ready,
  output logic             load,
  output logic             wr_valid,
  output logic [CNT_W-1:0] wr_off,
  output logic             pf_valid,
  output logic [CNT_W-1:0] pf_off,
  output logic             busy,
  output logic             done,
  output logic             suspended,
  output logic [CNT_W-1:0] remaining,
  output logic             write_fire,
  output logic             chunk_open
);
  localparam int CW = $clog2(CHUNK);
  localparam int HW = CNT_W + 2;

  blkz_state_e     st;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] off_q;
  logic [CW:0]      left_q;
  logic [HW-1:0]    hint_q;
  logic [HW-1:0]    hint_nx;
  logic             done_q;
  logic             susp_q;

  // Words in the chunk that starts with r words left: ((r-1) mod CHUNK)+1.
  function automatic logic [CW:0] chunk_words(input logic [CNT_W-1:0] r);
    logic [CNT_W-1:0] m1;
    m1 = r - 1'b1;
    return {1'b0, m1[CW-1:0]} + 1'b1;
  endfunction

  // A hint offset is usable when it is not negative.
  function automatic logic hint_ok(input logic [HW-1:0] h);
    return !h[HW-1];
  endfunction

  always_comb begin
    load       = start && (st == ST_IDLE);
    write_fire = (st == ST_WRITE) && wr_ready;
    chunk_open = (st == ST_ENTRY) && !irq_pending;
    hint_nx    = hint_q - HW'(CHUNK);
    pf_valid   = ((st == ST_LAUNCH) && (rem_q != '0) && hint_ok(hint_q)) ||
                 ((st == ST_ENTRY) && hint_ok(hint_nx));
    pf_off     = (st == ST_LAUNCH) ? hint_q[CNT_W-1:0] : hint_nx[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      rem_q  <= '0;
      off_q  <= '0;
      left_q <= '0;
      hint_q <= '0;
      done_q <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (load) begin
            rem_q  <= count;
            hint_q <= {2'b00, count} - HW'(CHUNK + 1);
            done_q <= 1'b0;
            susp_q <= 1'b0;
            st     <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          if (rem_q == '0) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            st <= ST_ENTRY;
          end
        end
        ST_ENTRY: begin
          hint_q <= hint_nx;
          if (irq_pending) begin
            susp_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            left_q <= chunk_words(rem_q);
            off_q  <= rem_q - 1'b1;
            st     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            off_q  <= off_q - 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == (CW+1)'(1)) begin
              rem_q <= off_q;
              if (off_q == '0) begin
                done_q <= 1'b1;
                st     <= ST_IDLE;
              end else begin
                st <= ST_ENTRY;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid  = (st == ST_WRITE);
  assign wr_off    = off_q;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign suspended = susp_q;
  assign remaining = rem_q;
endmodule

// File: rtl/blkz_engine.sv
module blkz_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int CHUNK  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              irq_pending,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              busy,
  output logic              done,
  output logic              suspended,
  output logic [CNT_W-1:0]  remaining
);
  logic             load;
  logic [CNT_W-1:0] wr_off;
  logic [CNT_W-1:0] pf_off;
  logic             write_fire;
  logic             chunk_open;
  logic [ADDR_W-1:0] base_hold;

  blkz_fsm #(.CNT_W(CNT_W), .CHUNK(CHUNK)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .irq_pending(irq_pending), .wr_ready(wr_ready), .load(load),
    .wr_valid(wr_valid), .wr_off(wr_off), .pf_valid(pf_valid),
    .pf_off(pf_off), .busy(busy), .done(done), .suspended(suspended),
    .remaining(remaining), .write_fire(write_fire), .chunk_open(chunk_open)
  );

  blkz_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .base_in(base_addr),
    .wr_off(wr_off), .pf_off(pf_off), .base_hold(base_hold),
    .wr_addr(wr_addr), .pf_addr(pf_addr)
  );

  assign wr_data = '0;
endmodule

// File: rtl/blkz_chk.sv
module blkz_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  count,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              busy,
  input logic              done,
  input logic              suspended,
  input logic [CNT_W-1:0]  remaining,
  input logic              write_fire,
  input logic              chunk_open,
  input logic [ADDR_W-1:0] base_hold
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr))); // R8

  AST_WR_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    write_fire |=> (!wr_valid || (wr_addr == $past(wr_addr) - 1'b1))); // R1

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (count == '0)) |=> (!wr_valid ##1 (done && !busy))); // R2

  AST_REM_IN_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid)) |-> $stable(remaining)); // R4

  AST_OPEN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_open |-> (remaining != '0)); // R4

  AST_HINT_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr >= base_hold)); // R7

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && suspended) && !(busy && (done || suspended))); // R9

  AST_SUSP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> !wr_valid); // R6
endmodule

bind blkz_engine blkz_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .count(count),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .pf_valid(pf_valid), .pf_addr(pf_addr), .busy(busy), .done(done),
  .suspended(suspended), .remaining(remaining), .write_fire(write_fire),
  .chunk_open(chunk_open), .base_hold(base_hold)
);

// File: tb/blkz_engine_tb.sv
`timescale 1ns/1ps
module blkz_engine_tb;
  localparam int AW = 8;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam int CH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] count = '0;
  logic          irq = 1'b0;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          wr_ready = 1'b1;
  logic          pf_valid;
  logic [AW-1:0] pf_addr;
  logic          busy, done, suspended;
  logic [CW-1:0] remaining;

  int checks = 0;
  int errors = 0;

  blkz_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .CHUNK(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .count(count), .irq_pending(irq), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .pf_valid(pf_valid),
    .pf_addr(pf_addr), .busy(busy), .done(done), .suspended(suspended),
    .remaining(remaining)
  );

  always #2 clk = ~clk;

  // Monitor state
  logic [AW-1:0] cur_base = '0;
  int exp_top = 0;
  int wr_n = 0;
  int wr_bad = 0;
  int irq_at = -1;
  int pf_n = 0;
  int pf_obs [0:63];
  int rmode = 0;
  int cyc = 0;

  always @(posedge clk) begin
    #1;
    cyc++;
    wr_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      if (wr_addr != AW'(int'(cur_base) + exp_top - wr_n) || wr_data != '0)
        wr_bad++;
      wr_n++;
      if (irq_at > 0 && wr_n >= irq_at) irq = 1'b1;
    end
    if (pf_valid) begin
      if (pf_n < 64) pf_obs[pf_n] = int'(AW'(pf_addr - cur_base));
      pf_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_len(input int c);
    return ((c - 1) % CH) + 1;
  endfunction

  task automatic run_job(input int b, input int c, input bit mid_pulse);
    @(negedge clk);
    base_addr = AW'(b);
    count = CW'(c);
    cur_base = AW'(b);
    exp_top = c - 1;
    wr_n = 0; wr_bad = 0; pf_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4000 && busy; k++) begin
      if (mid_pulse && k == 3) begin
        base_addr = AW'(b + 9); count = CW'(3); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    base_addr = AW'(b);
  endtask

  task automatic check_pf(input int c, input string tag);
    int n_exp = 0;
    bit ok = 1'b1;
    int nch = (c + CH - 1) / CH;
    for (int j = 1; j <= nch + 1; j++) begin
      int o = c - 1 - CH * j;
      if (o >= 0) begin
        if (n_exp >= pf_n || pf_obs[n_exp] != o) ok = 1'b0;
        n_exp++;
      end
    end
    check(ok && n_exp == pf_n, tag, pf_n, n_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !done && !suspended && !wr_valid && !pf_valid && remaining == 0,
          "R9 reset state", {busy, done, suspended}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero count timing
    base_addr = 8'd20; count = '0; cur_base = 8'd20; exp_top = -1;
    wr_n = 0; wr_bad = 0; pf_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R2 zero count busy one cycle", {busy, done}, 2);
    @(negedge clk);
    check(done && !busy && wr_n == 0 && pf_n == 0, "R2 zero count done no write",
          wr_n, 0);

    // R1 R4 R5 R7 R8 R9: full sweep
    for (int bi = 0; bi < 2; bi++) begin
      for (int rm = 0; rm < 2; rm++) begin
        rmode = rm;
        for (int c = 0; c < 64; c++) begin
          int b = (bi == 0) ? 0 : 150;
          run_job(b, c, 1'b0);
          check(wr_n == c && wr_bad == 0, "R1 R8 descending zero writes", wr_n, c);
          check(done && !suspended && !busy, "R9 done flags", {done, suspended}, 2);
          check(remaining == 0, "R4 remaining zero at done", int'(remaining), 0);
          check_pf(c, "R5 R7 hint offsets");
        end
      end
    end
    rmode = 1;

    // R6: interrupt already pending at start
    irq = 1'b1; irq_at = -1;
    run_job(30, 20, 1'b0);
    check(suspended && !done && wr_n == 0, "R6 suspend before first chunk", wr_n, 0);
    check(remaining == 20, "R6 remaining after early suspend", int'(remaining), 20);
    irq = 1'b0;

    // R3 R6: interrupt after the first (partial) chunk, then resume
    for (int t = 0; t < 5; t++) begin
      int c = (t == 0) ? 5 : (t == 1) ? 9 : (t == 2) ? 18 : (t == 3) ? 40 : 63;
      int fl = first_len(c);
      irq = 1'b0; irq_at = fl;
      run_job(60, c, 1'b0);
      check(suspended && wr_n == fl && wr_bad == 0, "R3 first chunk length", wr_n, fl);
      check(remaining == c - fl, "R6 remaining after suspend", int'(remaining), c - fl);
      irq = 1'b0; irq_at = -1;
      run_job(60, c - fl, 1'b0);
      check(done && wr_n == c - fl && wr_bad == 0, "R6 resume clears rest", wr_n, c - fl);
    end

    // R3: later chunks are full
    irq = 1'b0; irq_at = first_len(40) + CH;
    run_job(10, 40, 1'b0);
    check(suspended && wr_n == first_len(40) + CH, "R3 later chunk full",
          wr_n, first_len(40) + CH);
    check(remaining == 40 - first_len(40) - CH, "R4 remaining per chunk",
          int'(remaining), 40 - first_len(40) - CH);
    irq = 1'b0; irq_at = -1;

    // R9: start ignored while busy
    run_job(70, 30, 1'b1);
    check(done && wr_n == 30 && wr_bad == 0, "R9 start ignored while busy", wr_n, 30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule